// File: doc/BRIEF.md
# SPI Register Access Slave Port

This block is a serial slave that lets a host processor read and write a bank of 16-bit registers over a four-wire SPI bus in mode 3 (clock idles high, data captured on the rising edge, changed on the falling edge). Each transfer is a 16-bit frame, most significant bit first. The frame carries a direction flag, a 7-bit byte address and, for writes, a single data byte. Writes land one byte at a time. A read names a word, and the whole word comes back during the following frame. The host can therefore place its next request in the same frame that returns the previous answer, and keep the bus busy in full duplex.

All bus inputs are oversampled in the system clock domain through a two-stage synchronizer, and an edge detector turns the serial clock into capture and shift strobes. The bank holds a parameterised writable register file, a status word whose flags are cleared by reading it, and a fixed identification word. Every other address is unused: it reads as zero and ignores writes. A chip-select window whose clock count is not a whole number of frames raises a framing-error flag in the status word. The output driver is modelled as a data bit plus an output-enable.

Top module: `spi_reg_port`

## Requirements
- R1: MOSI is captured on rising SCLK edges while chip select is low, MSB first, in 16-bit frames laid out as bit 15 = write flag (1 = write, 0 = read), bits 14:8 = byte address, bits 7:0 = write data.
- R2: A write to an address inside the register file (byte addresses 0x20 to 0x2F by default) updates one byte of word address>>1: an even address sets bits 7:0, an odd address sets bits 15:8, and the other byte is unchanged; for example frame 0xA203 writes 0x03 into the low byte at 0x22.
- R3: A read returns the word selected by address bits 6:1; address bit 0 and the data byte are ignored. The word is shifted out on MISO during the next complete frame, MSB first, changing on falling SCLK edges.
- R4: Frames may follow one another without releasing chip select; each group of 16 clocks is a frame, and the answer to one frame's request comes out during the frame after it.
- R5: miso_oe_o is high only while chip select is low and the most recent complete frame was a read; after a write frame, or with chip select high, it is low.
- R6: Byte address 0x00 is the identification word and always reads 0x3F08; writes to it have no effect.
- R7: Byte address 0x02 is the status word. Bit 3 is set when chip select rises after a count of rising SCLK edges that is not a multiple of 16. A read returns the flags as they were and then clears them all; writes have no effect.
- R8: A frame cut short by chip select rising performs no write and issues no request; the pending answer is re-sent in full during the next complete frame.
- R9: Addresses outside the register file, the status word and the identification word read 0x0000 and ignore writes.
- R10: Reset clears the register file and the status word and leaves the output-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; oversamples the bus |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock from host, idles high |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output-enable for miso_o; low means high-impedance |

## Verification
The hardest state to reach from the pins is an aborted frame that sits between a read request and its answer: the held word must survive a chip-select window with a stray clock count, and the framing flag must then appear exactly once. The bench drives transfers whose length in clocks is chosen per call (7, 17 or a full multiple of 16), so it can cut a frame off mid-way or overrun it by one edge, and then follows with full frames that read back the held answer, the status word and its cleared value. Long chip-select windows carrying three frames check that a multiple of 16 raises no flag.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ERR_BIT    = 3;
    localparam logic [15:0] ID_VALUE = 16'h3F08;
endpackage

// File: rtl/spireg_sync.sv
// Oversampling synchronizer and edge detector for the serial bus inputs.
module spireg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic cs_ni,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_rise_o,
    output logic cs_low_o,
    output logic mosi_o
);
    typedef struct packed {
        logic [STAGES-1:0] sclk;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mosi;
        logic              sclk_prev;
        logic              csn_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d           = q;
        d.sclk      = {q.sclk[STAGES-2:0], sclk_i};
        d.csn       = {q.csn[STAGES-2:0], cs_ni};
        d.mosi      = {q.mosi[STAGES-2:0], mosi_i};
        d.sclk_prev = q.sclk[STAGES-1];
        d.csn_prev  = q.csn[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.sclk      <= '1;
            q.csn       <= '1;
            q.mosi      <= '0;
            q.sclk_prev <= 1'b1;
            q.csn_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise_o = q.sclk[STAGES-1] & ~q.sclk_prev;
    assign sclk_fall_o = ~q.sclk[STAGES-1] & q.sclk_prev;
    assign cs_rise_o   = q.csn[STAGES-1] & ~q.csn_prev;
    assign cs_low_o    = ~q.csn[STAGES-1];
    assign mosi_o      = q.mosi[STAGES-1];
endmodule

// File: rtl/spireg_frame.sv
// Bit counter, receive shifter and one-frame-late transmit shifter.
module spireg_frame
    import spireg_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        cs_low_i,
    input  logic        cs_rise_i,
    input  logic        mosi_i,
    input  logic [15:0] resp_i,
    output logic [15:0] word_o,
    output logic        done_o,
    output logic        err_o,
    output logic        miso_o,
    output logic        drive_o
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [15:0]   rx;
        logic [15:0]   tx;
        logic [15:0]   hold;
        logic          vld;
        logic          dout;
    } frm_t;

    frm_t q, d;

    assign word_o = {q.rx[14:0], mosi_i};
    assign done_o = cs_low_i & rise_i & (q.cnt == LAST);
    assign err_o  = cs_rise_i & (q.cnt != '0);

    always_comb begin
        d = q;
        if (!cs_low_i) begin
            d.cnt = '0;
            d.tx  = q.hold;
        end else if (rise_i) begin
            d.rx  = {q.rx[14:0], mosi_i};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.hold = resp_i;
                d.tx   = resp_i;
                d.vld  = ~word_o[15];
            end
        end else if (fall_i) begin
            d.dout = q.tx[15];
            d.tx   = {q.tx[14:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso_o  = q.dout;
    assign drive_o = q.vld;
endmodule

// File: rtl/spireg_bank.sv
// Register file, clear-on-read status word and identification word.
module spireg_bank
    import spireg_pkg::*;
#(
    parameter int          NREGS     = 8,
    parameter logic [6:0]  REG_BASE  = 7'h20,
    parameter logic [6:0]  STAT_ADDR = 7'h02,
    parameter logic [6:0]  ID_ADDR   = 7'h00
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        done_i,
    input  logic [15:0] word_i,
    input  logic        err_i,
    output logic [15:0] rdata_o,
    output logic [15:0] status_o
);
    localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [5:0] RF_LO = REG_BASE[6:1];
    localparam logic [6:0] RF_HI = {1'b0, RF_LO} + 7'(NREGS);
    localparam logic [5:0] ST_W  = STAT_ADDR[6:1];
    localparam logic [5:0] ID_W  = ID_ADDR[6:1];

    typedef struct packed {
        logic [NREGS-1:0][15:0] regs;
        logic [15:0]            status;
    } bank_t;

    bank_t q, d;

    logic            wr;
    logic [6:0]      addr;
    logic [7:0]      data;
    logic [5:0]      wsel;
    logic            rf_hit;
    logic [IDXW-1:0] idx;

    always_comb begin
        d      = q;
        wr     = word_i[15];
        addr   = word_i[14:8];
        data   = word_i[7:0];
        wsel   = addr[6:1];
        rf_hit = (wsel >= RF_LO) && ({1'b0, wsel} < RF_HI);
        idx    = IDXW'(wsel - RF_LO);

        rdata_o = '0;
        if (wsel == ID_W) begin
            rdata_o = ID_VALUE;
        end else if (wsel == ST_W) begin
            rdata_o = q.status;
        end else if (rf_hit) begin
            rdata_o = q.regs[idx];
        end

        if (done_i) begin
            if (wr) begin
                if (rf_hit) begin
                    if (addr[0]) begin
                        d.regs[idx][15:8] = data;
                    end else begin
                        d.regs[idx][7:0] = data;
                    end
                end
            end else if (wsel == ST_W) begin
                d.status = '0;
            end
        end
        if (err_i) begin
            d.status[ERR_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.status;
endmodule

// File: rtl/spi_reg_port.sv
// Mode-3 SPI slave giving byte-write, word-read access to a register bank.
module spi_reg_port #(
    parameter int          SYNC_STAGES = 2,
    parameter int          NREGS       = 8,
    parameter logic [6:0]  REG_BASE    = 7'h20,
    parameter logic [6:0]  STAT_ADDR   = 7'h02,
    parameter logic [6:0]  ID_ADDR     = 7'h00
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic cs_ni,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);
    logic        s_rise, s_fall, c_rise, c_low, s_mosi;
    logic [15:0] frm_word, rdata, status;
    logic        frm_done, frm_err, resp_vld;

    spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sclk_i),
        .cs_ni       (cs_ni),
        .mosi_i      (mosi_i),
        .sclk_rise_o (s_rise),
        .sclk_fall_o (s_fall),
        .cs_rise_o   (c_rise),
        .cs_low_o    (c_low),
        .mosi_o      (s_mosi)
    );

    spireg_frame u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (s_rise),
        .fall_i    (s_fall),
        .cs_low_i  (c_low),
        .cs_rise_i (c_rise),
        .mosi_i    (s_mosi),
        .resp_i    (rdata),
        .word_o    (frm_word),
        .done_o    (frm_done),
        .err_o     (frm_err),
        .miso_o    (miso_o),
        .drive_o   (resp_vld)
    );

    spireg_bank #(
        .NREGS     (NREGS),
        .REG_BASE  (REG_BASE),
        .STAT_ADDR (STAT_ADDR),
        .ID_ADDR   (ID_ADDR)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .done_i   (frm_done),
        .word_i   (frm_word),
        .err_i    (frm_err),
        .rdata_o  (rdata),
        .status_o (status)
    );

    assign miso_oe_o = resp_vld & ~cs_ni;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spireg_pkg::*;
#(
    parameter logic [6:0] STAT_ADDR = 7'h02
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        cs_ni,
    input logic        miso_oe_o,
    input logic        done,
    input logic [6:0]  hdr,
    input logic        err,
    input logic        vld,
    input logic [15:0] status
);
    // R7
    stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done && !hdr[6] && (hdr[5:0] == STAT_ADDR[6:1])) |=> (status == 16'h0000));

    // R7
    stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err |=> status[ERR_BIT]);

    // R7
    stat_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status[ERR_BIT]) |-> $past(err));

    // R5
    oe_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done && hdr[6]) |=> !vld);

    // R5
    oe_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done && !hdr[6]) |=> vld);

    // R5
    oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_ni |-> !miso_oe_o);
endmodule

bind spi_reg_port spi_reg_port_chk #(.STAT_ADDR(STAT_ADDR)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .miso_oe_o (miso_oe_o),
    .done      (frm_done),
    .hdr       (frm_word[15:9]),
    .err       (frm_err),
    .vld       (resp_vld),
    .status    (status)
);

// File: tb/sim_spi_reg_port.sv
`timescale 1ns/1ps
module sim_spi_reg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam int HALF = 6;

    always #2.5 clk = ~clk;

    spi_reg_port u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sclk_i    (sclk),
        .cs_ni     (cs_n),
        .mosi_i    (mosi),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    typedef struct packed {
        logic [15:0] frm;
        logic [15:0] rsp;
        logic        oe;
        logic [3:0]  req;
    } vec_t;

    // Each row: frame sent, answer expected during it (to the previous row), expected enable.
    localparam vec_t VECS [19] = '{
        '{16'hA203, 16'h0000, 1'b0, 4'd2},   // R2 write low byte 0x22
        '{16'hA301, 16'h0000, 1'b0, 4'd2},   // R2 write high byte 0x23
        '{16'h2200, 16'h0000, 1'b0, 4'd3},   // R3 request word 0x22
        '{16'h235A, 16'h0103, 1'b1, 4'd2},   // R2 both bytes landed
        '{16'h0000, 16'h0103, 1'b1, 4'd3},   // R3 odd address and data ignored
        '{16'hA0FF, 16'h3F08, 1'b1, 4'd6},   // R6 identification word
        '{16'h8044, 16'h0000, 1'b0, 4'd5},   // R5 after write: no drive
        '{16'h0000, 16'h0000, 1'b0, 4'd5},   // R5 after write: no drive
        '{16'h2000, 16'h3F08, 1'b1, 4'd6},   // R6 write to id ignored
        '{16'h7E00, 16'h00FF, 1'b1, 4'd2},   // R2 low byte of 0x20
        '{16'hFE12, 16'h0000, 1'b1, 4'd9},   // R9 unused address reads zero
        '{16'h7E00, 16'h0000, 1'b0, 4'd5},   // R5
        '{16'h0200, 16'h0000, 1'b1, 4'd9},   // R9 write to unused ignored
        '{16'h0200, 16'h0000, 1'b1, 4'd7},   // R7 status empty
        '{16'h2E00, 16'h0000, 1'b1, 4'd7},   // R7 status still empty
        '{16'hAEAB, 16'h0000, 1'b1, 4'd3},   // R3 last word after reset
        '{16'h2E00, 16'h0000, 1'b0, 4'd5},   // R5
        '{16'h3000, 16'h00AB, 1'b1, 4'd2},   // R2 last word of the file
        '{16'h0000, 16'h0000, 1'b1, 4'd9}    // R9 just above the file
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: drive nbits clocks, MSB first, data changed while SCLK is low.
    task automatic xfer(input logic [15:0] w, input int nbits, input bit keep_cs,
                        output logic [15:0] got, output logic oe_seen);
        got = '0;
        oe_seen = 1'b0;
        if (cs_n) begin
            cs_n = 1'b0;
            wait_clk(HALF);
        end
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = w[15 - (i % 16)];
            wait_clk(HALF);
            if (i == 0) oe_seen = miso_oe;
            if (i < 16) got = {got[14:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
        end
        if (!keep_cs) begin
            wait_clk(4);
            cs_n = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic expect_frame(input logic [15:0] w, input int nbits, input bit keep_cs,
                                input logic [15:0] exp, input string req);
        logic [15:0] got;
        logic oe;
        xfer(w, nbits, keep_cs, got, oe);
        check(oe === 1'b1, req, {15'b0, oe}, 16'h0001);
        check(got === exp, req, got, exp);
    endtask

    initial begin
        logic [15:0] got;
        logic oe;
        wait_clk(5);
        // R10 enable low in reset
        check(miso_oe === 1'b0, "R10", {15'b0, miso_oe}, 16'h0000);
        rst_n = 1'b1;
        wait_clk(4);
        check(miso_oe === 1'b0, "R10", {15'b0, miso_oe}, 16'h0000);

        for (int k = 0; k < 19; k++) begin
            xfer(VECS[k].frm, 16, 1'b0, got, oe);
            check(oe === VECS[k].oe, $sformatf("R%0d", VECS[k].req), {15'b0, oe},
                  {15'b0, VECS[k].oe});
            if (VECS[k].oe)
                check(got === VECS[k].rsp, $sformatf("R%0d", VECS[k].req), got, VECS[k].rsp);
        end

        // R4 three frames inside one chip-select window
        xfer(16'h2000, 16, 1'b1, got, oe);
        expect_frame(16'h0200, 16, 1'b1, 16'h00FF, "R4");
        expect_frame(16'h0000, 16, 1'b0, 16'h0000, "R4");
        // R5 read pending but chip select high: no drive
        check(miso_oe === 1'b0, "R5", {15'b0, miso_oe}, 16'h0000);

        // R8 abort between a read and its answer
        xfer(16'h2200, 16, 1'b0, got, oe);
        xfer(16'hA055, 7, 1'b0, got, oe);
        expect_frame(16'h0200, 16, 1'b0, 16'h0103, "R8");
        expect_frame(16'h2000, 16, 1'b0, 16'h0008, "R7");
        expect_frame(16'h0200, 16, 1'b0, 16'h00FF, "R8");
        expect_frame(16'h0000, 16, 1'b0, 16'h0000, "R7");

        // R7 one clock too many also flags; R8 answer re-sent after overrun
        xfer(16'h0000, 17, 1'b0, got, oe);
        expect_frame(16'h0200, 16, 1'b0, 16'h3F08, "R8");
        expect_frame(16'h0000, 16, 1'b0, 16'h0008, "R7");

        // R10 reset clears the file and the enable
        rst_n = 1'b0;
        wait_clk(4);
        check(miso_oe === 1'b0, "R10", {15'b0, miso_oe}, 16'h0000);
        rst_n = 1'b1;
        wait_clk(4);
        xfer(16'h2200, 16, 1'b0, got, oe);
        check(oe === 1'b0, "R10", {15'b0, oe}, 16'h0000);
        expect_frame(16'h2000, 16, 1'b0, 16'h0000, "R10");
        expect_frame(16'h0000, 16, 1'b0, 16'h0000, "R10");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule